// File: doc/BRIEF.md
# PCM Bus Interleaver

This block time-shares one fast serial bus among several 2.048 Mbit/s framer lanes, and takes such a bus apart again into per-lane bytes. Each lane hands in one byte at a time for the timeslot the block asks for. The block shifts that byte onto the shared bus MSB first inside the lane's own slot window, and raises that lane's slot enable for the same bit periods. On the receive side the block watches the bus at the same positions and rebuilds each lane's bytes.

Two bus rates are supported. In the 4.096 MHz setting, lanes 0 and 1 share bus 0 and lanes 2 and 3 share bus 1. In the 8.192 MHz setting, all four lanes share bus 0. Lanes can be interleaved a byte at a time or a whole frame at a time. On each bus the lowest lane is the master: it starts the bit-position counter from the shared frame sync. Every other lane on that bus is a slave and finds its window from its lane index, taken as an offset within the master's count.

Top module: `pcm_bus_interleaver`

## Requirements
- R1: After reset and until the first frame sync, every slot enable is low, both bus outputs are low and no receive valid is raised.
- R2: The cycle in which `fsync` is high is bus bit position 0. The position then advances by one per clock. A later `fsync` forces position 0 again, whatever the current position.
- R3: With `cfg_fast`=1 (8.192 MHz), a frame on bus 0 is 1024 bit positions and wraps from 1023 to 0 without a new sync. Bus 1 stays low.
- R4: With `cfg_fast`=0 (4.096 MHz), each bus frame is 512 positions. Lanes 0 and 1 use bus 0 and lanes 2 and 3 use bus 1. Both buses run in step, timed by lanes 0 and 2.
- R5: With `cfg_frame`=0 (byte interleave) and N lanes per bus, position p belongs to local lane (p/8) mod N, timeslot (p/8)/N. Local lane is the lane index in fast mode, and the lane index mod 2 otherwise.
- R6: With `cfg_frame`=1 (frame interleave), position p belongs to local lane p/256, timeslot (p/8) mod 32. Each lane's 32 bytes go out as one contiguous block, with lanes in ascending order.
- R7: Within a slot, bit p mod 8 of the position carries byte bit 7-(p mod 8), so the MSB goes first. The byte used is the one present on `lane_tx_byte` during the slot's first bit. `lane_tx_ts` shows the timeslot of the current position.
- R8: At any time at most one lane per bus has its slot enable high. A bus is high only when one of its lanes is enabled.
- R9: The enable and bus bit for position p appear one clock after the edge at which position p is current.
- R10: Received bits are taken from `bus_rx` one clock after their position is current, so a direct loopback of `bus_tx` is aligned. Each completed byte is presented MSB-first on `lane_rx_byte` with its timeslot on `lane_rx_ts`, together with a one-cycle `lane_rx_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | Shared frame sync, high for the position-0 cycle |
| cfg_fast | input | 1 | 1: one 8.192 MHz bus of four lanes; 0: two 4.096 MHz buses of two lanes |
| cfg_frame | input | 1 | 1: frame interleave; 0: byte interleave |
| lane_tx_byte | input | 32 | Transmit byte per lane, lane k at bits 8k+7:8k |
| lane_tx_ts | output | 20 | Timeslot requested per lane, lane k at bits 5k+4:5k |
| lane_slot_en | output | 4 | Per-lane slot enable, bit k for lane k |
| bus_tx | output | 2 | Serial bus outputs, bit 0 for bus 0 and bit 1 for bus 1 |
| bus_rx | input | 2 | Serial bus inputs, same bit order as bus_tx |
| lane_rx_byte | output | 32 | Received byte per lane, lane k at bits 8k+7:8k |
| lane_rx_ts | output | 20 | Timeslot of the received byte, lane k at bits 5k+4:5k |
| lane_rx_valid | output | 4 | One-cycle strobe per lane for a new received byte |

## Verification
The bench goes after the ownership arithmetic in both rates and both granularities, on every position of whole frames. A wrong modulus or shift would put a byte in another lane's window, or overlap two enables on one bus. It drives a second sync in the middle of a frame and runs two frames without one. A counter that ignores the resync, or that wraps at the wrong length, would shift every later slot. A receive path sampling in the wrong cycle would return bytes rotated by a bit. An inverted loopback on bus 0 only proves that the rebuilt bytes come from `bus_rx` and not from the transmit side.

// File: rtl/pcm_il_pkg.sv
package pcm_il_pkg;

  parameter int LANES        = 4;
  parameter int BUSES        = 2;
  parameter int BYTE_W       = 8;
  parameter int TS_PER_FRAME = 32;

  localparam int HALF       = LANES / 2;
  localparam int FRAME_BITS = TS_PER_FRAME * BYTE_W;
  localparam int POS_W      = $clog2(LANES * FRAME_BITS);
  localparam int TS_W       = $clog2(TS_PER_FRAME);
  localparam int LANE_W     = $clog2(LANES);
  localparam int BIT_W      = $clog2(BYTE_W);

  typedef logic [POS_W-1:0]  pos_t;
  typedef logic [TS_W-1:0]   ts_t;
  typedef logic [LANE_W-1:0] lane_t;
  typedef logic [BIT_W-1:0]  bit_t;

  // highest bit position of one bus frame
  function automatic pos_t last_pos(input logic fast);
    if (fast) return pos_t'(LANES * FRAME_BITS - 1);
    return pos_t'(HALF * FRAME_BITS - 1);
  endfunction

  // local lane index owning a bus position
  function automatic lane_t slot_owner(input pos_t pos, input logic fast,
                                       input logic frame);
    int unsigned p;
    p = 32'(pos);
    if (frame) return lane_t'(p / FRAME_BITS);
    if (fast)  return lane_t'((p / BYTE_W) % LANES);
    return lane_t'((p / BYTE_W) % HALF);
  endfunction

  // timeslot carried at a bus position
  function automatic ts_t slot_ts(input pos_t pos, input logic fast,
                                  input logic frame);
    int unsigned p;
    p = 32'(pos);
    if (frame) return ts_t'((p / BYTE_W) % TS_PER_FRAME);
    if (fast)  return ts_t'(p / (BYTE_W * LANES));
    return ts_t'(p / (BYTE_W * HALF));
  endfunction

  // bit number within the slot (0 = MSB sent first)
  function automatic bit_t bit_of(input pos_t pos);
    return bit_t'(32'(pos) % BYTE_W);
  endfunction

  // position of a lane among the lanes of its bus
  function automatic lane_t lane_local(input int idx, input logic fast);
    if (fast) return lane_t'(idx);
    return lane_t'(idx % HALF);
  endfunction

  // bus a lane is attached to
  function automatic logic lane_bus(input int idx, input logic fast);
    if (fast) return 1'b0;
    return (idx / HALF) != 0;
  endfunction

endpackage

// File: rtl/pcm_il_slot_ctr.sv
module pcm_il_slot_ctr
  import pcm_il_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic fsync,
  input  logic cfg_fast,
  output pos_t pos,
  output logic synced
);

  pos_t cnt_q;
  logic seen_q;
  logic at_last;

  always_comb begin
    pos     = fsync ? '0 : cnt_q;
    synced  = fsync | seen_q;
    at_last = (pos == last_pos(cfg_fast));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      seen_q <= synced;
      cnt_q  <= at_last ? '0 : pos + 1'b1;
    end
  end

endmodule

// File: rtl/pcm_il_lane_tx.sv
module pcm_il_lane_tx
  import pcm_il_pkg::*;
#(
  parameter int LANE_IDX = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_fast,
  input  logic              cfg_frame,
  input  logic              synced,
  input  pos_t              pos,
  input  logic [BYTE_W-1:0] tx_byte,
  output ts_t               tx_ts,
  output logic              slot_en,
  output logic              tx_bit
);

  logic              in_win;
  logic              win_start;
  bit_t              bit_idx;
  logic [BYTE_W-2:0] sh_q;

  always_comb begin
    in_win    = synced &&
                (slot_owner(pos, cfg_fast, cfg_frame) == lane_local(LANE_IDX, cfg_fast));
    bit_idx   = bit_of(pos);
    win_start = in_win && (bit_idx == '0);
    tx_ts     = slot_ts(pos, cfg_fast, cfg_frame);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_en <= 1'b0;
      tx_bit  <= 1'b0;
      sh_q    <= '0;
    end else begin
      slot_en <= in_win;
      if (win_start) begin
        tx_bit <= tx_byte[BYTE_W-1];
        sh_q   <= tx_byte[BYTE_W-2:0];
      end else if (in_win) begin
        tx_bit <= sh_q[BYTE_W-2];
        sh_q   <= {sh_q[BYTE_W-3:0], 1'b0};
      end else begin
        tx_bit <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/pcm_il_lane_rx.sv
module pcm_il_lane_rx
  import pcm_il_pkg::*;
#(
  parameter int LANE_IDX = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_fast,
  input  logic              cfg_frame,
  input  logic              synced,
  input  pos_t              pos,
  input  logic              rx_bit,
  output logic [BYTE_W-1:0] rx_byte,
  output ts_t               rx_ts,
  output logic              rx_valid
);

  logic              in_win;
  logic              win_d;
  bit_t              bit_d;
  ts_t               ts_d;
  logic              byte_done;
  logic [BYTE_W-2:0] sh_q;

  always_comb begin
    in_win    = synced &&
                (slot_owner(pos, cfg_fast, cfg_frame) == lane_local(LANE_IDX, cfg_fast));
    byte_done = win_d && (bit_d == bit_t'(BYTE_W - 1));
  end

  // position pipeline: bits on the bus lag their position by one clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_d <= 1'b0;
      bit_d <= '0;
      ts_d  <= '0;
    end else begin
      win_d <= in_win;
      bit_d <= bit_of(pos);
      ts_d  <= slot_ts(pos, cfg_fast, cfg_frame);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q     <= '0;
      rx_byte  <= '0;
      rx_ts    <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= byte_done;
      if (win_d) sh_q <= {sh_q[BYTE_W-3:0], rx_bit};
      if (byte_done) begin
        rx_byte <= {sh_q, rx_bit};
        rx_ts   <= ts_d;
      end
    end
  end

endmodule

// File: rtl/pcm_bus_interleaver.sv
module pcm_bus_interleaver
  import pcm_il_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     fsync,
  input  logic                     cfg_fast,
  input  logic                     cfg_frame,
  input  logic [LANES*BYTE_W-1:0]  lane_tx_byte,
  output logic [LANES*TS_W-1:0]    lane_tx_ts,
  output logic [LANES-1:0]         lane_slot_en,
  output logic [BUSES-1:0]         bus_tx,
  input  logic [BUSES-1:0]         bus_rx,
  output logic [LANES*BYTE_W-1:0]  lane_rx_byte,
  output logic [LANES*TS_W-1:0]    lane_rx_ts,
  output logic [LANES-1:0]         lane_rx_valid
);

  pos_t             pos_bus  [BUSES];
  logic [BUSES-1:0] sync_bus;
  logic [LANES-1:0] tx_bit;
  logic [LANES-1:0] rx_in;

  // named timing of bus 0 for the checker
  pos_t bus0_pos;
  logic bus0_synced;
  assign bus0_pos    = pos_bus[0];
  assign bus0_synced = sync_bus[0];

  // one position counter per bus, owned by the bus master lane
  for (genvar b = 0; b < BUSES; b++) begin : g_master
    pcm_il_slot_ctr u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .fsync    (fsync),
      .cfg_fast (cfg_fast),
      .pos      (pos_bus[b]),
      .synced   (sync_bus[b])
    );
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    pos_t lane_pos;
    logic lane_sync;
    assign lane_pos  = cfg_fast ? pos_bus[0]  : pos_bus[l / HALF];
    assign lane_sync = cfg_fast ? sync_bus[0] : sync_bus[l / HALF];
    assign rx_in[l]  = bus_rx[lane_bus(l, cfg_fast)];

    pcm_il_lane_tx #(.LANE_IDX(l)) u_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_fast  (cfg_fast),
      .cfg_frame (cfg_frame),
      .synced    (lane_sync),
      .pos       (lane_pos),
      .tx_byte   (lane_tx_byte[l*BYTE_W +: BYTE_W]),
      .tx_ts     (lane_tx_ts[l*TS_W +: TS_W]),
      .slot_en   (lane_slot_en[l]),
      .tx_bit    (tx_bit[l])
    );

    pcm_il_lane_rx #(.LANE_IDX(l)) u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_fast  (cfg_fast),
      .cfg_frame (cfg_frame),
      .synced    (lane_sync),
      .pos       (lane_pos),
      .rx_bit    (rx_in[l]),
      .rx_byte   (lane_rx_byte[l*BYTE_W +: BYTE_W]),
      .rx_ts     (lane_rx_ts[l*TS_W +: TS_W]),
      .rx_valid  (lane_rx_valid[l])
    );
  end

  // each lane's bit is zero outside its window, so the bus is a plain OR
  always_comb begin
    bus_tx = '0;
    for (int l = 0; l < LANES; l++) begin
      if (lane_bus(l, cfg_fast)) bus_tx[1] = bus_tx[1] | tx_bit[l];
      else                       bus_tx[0] = bus_tx[0] | tx_bit[l];
    end
  end

endmodule

// File: rtl/pcm_il_checker.sv
module pcm_il_checker
  import pcm_il_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             fsync,
  input logic             cfg_fast,
  input pos_t             bus0_pos,
  input logic             bus0_synced,
  input logic [LANES-1:0] lane_slot_en,
  input logic [BUSES-1:0] bus_tx,
  input logic [LANES-1:0] lane_rx_valid
);

  pos_t frame_end;
  assign frame_end = cfg_fast ? pos_t'(1023) : pos_t'(511);

  p_quiet_before_sync_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !bus0_synced |=> (lane_slot_en == '0 && bus_tx == '0 && lane_rx_valid == '0));

  p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus0_synced && bus0_pos != frame_end) |=> (fsync || bus0_pos == $past(bus0_pos) + 1'b1));

  p_sync_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fsync |=> (fsync || bus0_pos == pos_t'(1)));

  p_frame_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus0_synced && bus0_pos == frame_end) |=> (fsync || bus0_pos == '0));

  p_bus1_idle_fast_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_fast && $past(cfg_fast)) |-> !bus_tx[1]);

  p_one_owner_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_fast ? $onehot0(lane_slot_en)
             : ($onehot0(lane_slot_en[1:0]) && $onehot0(lane_slot_en[3:2])));

  p_bus_needs_owner_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_tx[0] |-> (cfg_fast ? (lane_slot_en != '0) : (lane_slot_en[1:0] != '0)));

  p_rx_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_rx_valid != '0) |=> ((lane_rx_valid & $past(lane_rx_valid)) == '0));

endmodule

bind pcm_bus_interleaver pcm_il_checker u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .fsync         (fsync),
  .cfg_fast      (cfg_fast),
  .bus0_pos      (bus0_pos),
  .bus0_synced   (bus0_synced),
  .lane_slot_en  (lane_slot_en),
  .bus_tx        (bus_tx),
  .lane_rx_valid (lane_rx_valid)
);

// File: tb/pcm_bus_interleaver_test.sv
module pcm_bus_interleaver_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fsync = 1'b0;
  logic        cfg_fast = 1'b0;
  logic        cfg_frame = 1'b0;
  logic        inv_c = 1'b0;
  int          seed_c = 0;
  logic [31:0] lane_tx_byte;
  logic [19:0] lane_tx_ts;
  logic [3:0]  lane_slot_en;
  logic [1:0]  bus_tx;
  logic [1:0]  bus_rx;
  logic [31:0] lane_rx_byte;
  logic [19:0] lane_rx_ts;
  logic [3:0]  lane_rx_valid;

  int tests = 0;
  int fails = 0;
  int rx_cnt [4];
  int rx_nxt [4];

  always #10 clk = ~clk;

  // test data: a byte per lane and timeslot
  function automatic logic [7:0] pat(input int k, input int ts, input int sd);
    return 8'(k * 71 + ts * 29 + sd);
  endfunction

  for (genvar k = 0; k < 4; k++) begin : g_src
    assign lane_tx_byte[k*8 +: 8] = pat(k, int'(lane_tx_ts[k*5 +: 5]), seed_c);
  end

  // loopback, optionally inverted on bus 0
  assign bus_rx = bus_tx ^ {1'b0, inv_c};

  pcm_bus_interleaver uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .fsync         (fsync),
    .cfg_fast      (cfg_fast),
    .cfg_frame     (cfg_frame),
    .lane_tx_byte  (lane_tx_byte),
    .lane_tx_ts    (lane_tx_ts),
    .lane_slot_en  (lane_slot_en),
    .bus_tx        (bus_tx),
    .bus_rx        (bus_rx),
    .lane_rx_byte  (lane_rx_byte),
    .lane_rx_ts    (lane_rx_ts),
    .lane_rx_valid (lane_rx_valid)
  );

  task automatic setup(input logic fast, input logic frame, input logic inv, input int sd);
    rst_n     = 1'b0;
    fsync     = 1'b0;
    cfg_fast  = fast;
    cfg_frame = frame;
    inv_c     = inv;
    seed_c    = sd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic start_frame();
    @(negedge clk);
    fsync = 1'b1;
    @(posedge clk);
    #2 fsync = 1'b0;
    for (int k = 0; k < 4; k++) begin
      rx_cnt[k] = 0;
      rx_nxt[k] = 0;
    end
  endtask

  // expected enables and bus bits for position p, from R3..R7
  task automatic check_pos(input int p, input string tag);
    int nb, loc, ts, b;
    logic [3:0] exp_en;
    logic [1:0] exp_bus;
    logic [7:0] d0, d1;
    nb = cfg_fast ? 4 : 2;
    b  = p % 8;
    if (cfg_frame) begin
      loc = p / 256;
      ts  = (p / 8) % 32;
    end else begin
      loc = (p / 8) % nb;
      ts  = (p / 8) / nb;
    end
    d0 = pat(loc, ts, seed_c);
    d1 = pat(loc + 2, ts, seed_c);
    exp_en     = 4'(1 << loc);
    exp_bus[0] = d0[7 - b];
    exp_bus[1] = 1'b0;
    if (!cfg_fast) begin
      exp_en     = exp_en | 4'(1 << (loc + 2));
      exp_bus[1] = d1[7 - b];
    end
    tests++;
    if (lane_slot_en !== exp_en || bus_tx !== exp_bus) begin
      fails++;
      $display("FAIL %s pos %0d: en=%b bus=%b expected en=%b bus=%b",
               tag, p, lane_slot_en, bus_tx, exp_en, exp_bus);
    end
  endtask

  task automatic check_rx(input logic seq);
    logic [7:0] exp_b;
    int ts;
    for (int k = 0; k < 4; k++) begin
      if (lane_rx_valid[k]) begin
        ts    = int'(lane_rx_ts[k*5 +: 5]);
        exp_b = pat(k, ts, seed_c);
        if (inv_c && (cfg_fast || k < 2)) exp_b = ~exp_b;
        tests++;
        if (lane_rx_byte[k*8 +: 8] !== exp_b || (seq && ts != rx_nxt[k])) begin
          fails++;
          $display("FAIL R10 lane %0d: byte=%h ts=%0d expected byte=%h ts=%0d",
                   k, lane_rx_byte[k*8 +: 8], ts, exp_b, rx_nxt[k]);
        end
        rx_nxt[k] = (rx_nxt[k] + 1) % 32;
        rx_cnt[k]++;
      end
    end
  endtask

  // R9: sample at each falling edge after the edge of position p
  task automatic check_span(input int n, input logic seq, input string tag);
    int m;
    m = cfg_fast ? 1024 : 512;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check_pos(i % m, tag);
      check_rx(seq);
    end
  endtask

  task automatic check_counts(input int exp_n);
    for (int k = 0; k < 4; k++) begin
      tests++;
      if (rx_cnt[k] != exp_n) begin
        fails++;
        $display("FAIL R10 lane %0d byte count: %0d expected %0d", k, rx_cnt[k], exp_n);
      end
    end
  endtask

  task automatic t_reset_quiet();
    setup(1'b1, 1'b0, 1'b0, 3);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      tests++;
      if (lane_slot_en !== 4'b0 || bus_tx !== 2'b0 || lane_rx_valid !== 4'b0) begin
        fails++;
        $display("FAIL R1 before sync: en=%b bus=%b valid=%b expected all zero",
                 lane_slot_en, bus_tx, lane_rx_valid);
      end
    end
  endtask

  task automatic t_fast_byte();
    setup(1'b1, 1'b0, 1'b0, 11);
    start_frame();
    check_span(1032, 1'b1, "R3 R5 R7 R8 R9");
    check_counts(32);
  endtask

  task automatic t_fast_frame();
    setup(1'b1, 1'b1, 1'b0, 57);
    start_frame();
    check_span(1032, 1'b1, "R3 R6 R7 R8");
    check_counts(32);
  endtask

  task automatic t_slow_byte();
    setup(1'b0, 1'b0, 1'b0, 90);
    start_frame();
    check_span(520, 1'b1, "R4 R5 R7");
    check_counts(32);
  endtask

  task automatic t_slow_frame();
    setup(1'b0, 1'b1, 1'b0, 140);
    start_frame();
    check_span(520, 1'b1, "R4 R6 R7");
    check_counts(32);
  endtask

  task automatic t_resync();
    setup(1'b1, 1'b0, 1'b0, 200);
    start_frame();
    check_span(300, 1'b0, "R2 pre");
    start_frame();
    check_span(600, 1'b1, "R2 after resync");
  endtask

  task automatic t_wrap();
    setup(1'b1, 1'b1, 1'b0, 33);
    start_frame();
    check_span(2 * 1024 + 8, 1'b1, "R3 wrap");
    check_counts(64);
  endtask

  task automatic t_rx_inverted();
    setup(1'b0, 1'b0, 1'b1, 77);
    start_frame();
    check_span(520, 1'b1, "R10 inverted");
    check_counts(32);
  endtask

  initial begin
    t_reset_quiet();
    t_fast_byte();
    t_fast_frame();
    t_slow_byte();
    t_slow_frame();
    t_resync();
    t_wrap();
    t_rx_inverted();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule